// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip. Its input is a test clock, a mode-select line, a serial data input and an active-low asynchronous reset. It drives a serial data output and the enable for that output. A sixteen-state controller steps through the standard scan graph. The graph has one data-register column and one instruction-register column. Each column has Select, Capture, Shift, Exit1, Pause, Exit2 and Update states. Test-Logic-Reset and Run-Test/Idle complete the sixteen. The block holds three scan paths. The first is an 8-bit instruction register with a separate parallel instruction latch. The second is a 1-bit bypass stage. The third is a 32-bit identification register.

The two external-scan opcodes do not drive any boundary cells inside this block. They select a 1-bit external scan stub and pulse its select, capture, shift and update strobes. The stub's serial output is routed back to the test data output. The identification opcode selects the 32-bit register. Every other code, including the all-ones opcode and all private opcodes, selects the bypass stage.

Two behaviours are kept on purpose. First, Test-Logic-Reset loads the all-ones instruction, so the identification path is never active straight out of reset. Second, no shift path holds its contents across a Pause state. Leaving Exit2 for Shift captures the register again instead of resuming the scan that was interrupted.

Top module: `tap_ctrl`

## Requirements
- R1: Driving `trst_n` low immediately forces Test-Logic-Reset and the all-ones instruction, and clears `tdo` and `tdo_en` without waiting for a clock edge.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: State changes on the rising edge of `tck`. With `tms` = 1 / 0 the next states are as follows. Reset goes to Reset / Idle. Idle goes to DR-Select / Idle. DR-Select goes to IR-Select / DR-Capture. IR-Select goes to Reset / IR-Capture. Capture goes to Exit1 / Shift. Shift goes to Exit1 / Shift. Exit1 goes to Update / Pause. Pause goes to Exit2 / Pause. Exit2 goes to Update / Shift. Both Updates go to DR-Select / Idle. Capture, Shift, Exit1, Pause and Exit2 stay within their own column.
- R4: On leaving IR-Capture, the instruction shift register loads 8'h01, so its two low bits are 01. In IR-Shift it moves one place per edge, least significant bit first, from `tdi` toward `tdo`.
- R5: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly when the controller is in IR-Shift or DR-Shift. When `tdo_en` is 0, `tdo` is 0.
- R6: The active instruction changes only on the edge that leaves IR-Update, when it takes the shifted value, or on an edge in Test-Logic-Reset. The decode is: 8'h00 and 8'h01 select the external stub, 8'h04 selects the identification register, and every other code (8'hFF, and private codes such as 8'h25) selects bypass.
- R7: With the identification register selected, DR-Capture loads 32'h8006302F. This value is version 4'b1000, part 16'h0063, maker 11'h017 and bit 0 = 1. The register shifts out least significant bit first.
- R8: With bypass selected, DR-Capture loads 0 into the single bypass stage. In DR-Shift the output lags `tdi` by one edge.
- R9: An edge in DR-Exit2 with `tms` = 0 recaptures the selected data register, as DR-Capture does. An edge in IR-Exit2 with `tms` = 0 reloads 8'h01 into the instruction register.
- R10: `ext_sel` is 1 while the instruction is 8'h00 or 8'h01. While it is 1, `ext_capture` is high in DR-Capture and in DR-Exit2 with `tms` low, `ext_shift` is high in DR-Shift, and `ext_update` is high in DR-Update. During DR-Shift, `tdo` carries `ext_so`.
- R11: After Test-Logic-Reset a data scan passes through the bypass stage and not the identification register, even if the identification opcode was active before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| ext_so | input | 1 | Serial output of the external scan stub |
| ext_sel | output | 1 | External stub selected by the instruction |
| ext_capture | output | 1 | External stub capture strobe |
| ext_shift | output | 1 | External stub shift strobe |
| ext_update | output | 1 | External stub update strobe |

## Verification
The recapture in both Exit2 states is the hardest behaviour to reach from the ports. The bench has to stop a scan partway, park in Pause, leave through Exit2 and re-enter Shift. It also has to choose how far the scan ran before the pause so that the bit of a resumed scan differs from the recaptured bit. For the identification register the scan stops after four shifts, where the next bit of the code is 0 and a fresh capture gives 1. For the instruction register it stops after two shifts, where the resumed bit is 0 and the capture pattern gives 1. A second hard case is an asynchronous reset asserted in the middle of a shift. This shows that the identification opcode does not survive reset.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET,   TS_IDLE,
        TS_DR_SEL,  TS_DR_CAP,  TS_DR_SHIFT, TS_DR_EXIT1,
        TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPD,
        TS_IR_SEL,  TS_IR_CAP,  TS_IR_SHIFT, TS_IR_EXIT1,
        TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPD
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_BYPASS,
        PATH_IDENT,
        PATH_EXTSCAN
    } dr_path_e;

    typedef struct packed {
        logic ir_load;    // capture or recapture of instruction register
        logic ir_shift;
        logic ir_update;
        logic dr_load;    // capture or recapture of data register
        logic dr_shift;
        logic dr_update;
        logic in_reset;
    } tap_ctl_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_ctl_t   ctl
);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   nxt = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_SHIFT: nxt = tms ? TS_DR_EXIT1 : TS_DR_SHIFT;
            TS_DR_EXIT1: nxt = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: nxt = tms ? TS_DR_EXIT2 : TS_DR_PAUSE;
            TS_DR_EXIT2: nxt = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   nxt = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_SHIFT: nxt = tms ? TS_IR_EXIT1 : TS_IR_SHIFT;
            TS_IR_EXIT1: nxt = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: nxt = tms ? TS_IR_EXIT2 : TS_IR_PAUSE;
            TS_IR_EXIT2: nxt = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   nxt = tms ? TS_DR_SEL   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // Exit2 back into Shift is treated as a fresh capture: no path keeps
    // its partial contents across a pause.
    always_comb begin
        ctl           = '0;
        ctl.ir_load   = (state == TS_IR_CAP) || ((state == TS_IR_EXIT2) && !tms);
        ctl.ir_shift  = (state == TS_IR_SHIFT);
        ctl.ir_update = (state == TS_IR_UPD);
        ctl.dr_load   = (state == TS_DR_CAP) || ((state == TS_DR_EXIT2) && !tms);
        ctl.dr_shift  = (state == TS_DR_SHIFT);
        ctl.dr_update = (state == TS_DR_UPD);
        ctl.in_reset  = (state == TS_RESET);
    end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
    import tap_pkg::*;
#(
    parameter int              IR_W        = 8,
    parameter logic [IR_W-1:0] CAPTURE_PAT = 'h01,
    parameter logic [IR_W-1:0] OP_EXTEST   = 'h00,
    parameter logic [IR_W-1:0] OP_SAMPLE   = 'h01,
    parameter logic [IR_W-1:0] OP_IDCODE   = 'h04,
    parameter logic [IR_W-1:0] OP_BYPASS   = '1
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    output logic     so,
    output dr_path_e path
);

    localparam int MSB = IR_W - 1;

    logic [MSB:0] sr_q;
    logic [MSB:0] instr_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q    <= CAPTURE_PAT;
            instr_q <= OP_BYPASS;
        end else begin
            if (ctl.ir_load)       sr_q <= CAPTURE_PAT;
            else if (ctl.ir_shift) sr_q <= {tdi, sr_q[MSB:1]};

            if (ctl.in_reset)       instr_q <= OP_BYPASS;
            else if (ctl.ir_update) instr_q <= sr_q;
        end
    end

    // Every code not claimed below, private or public, lands on bypass.
    always_comb begin
        if ((instr_q == OP_EXTEST) || (instr_q == OP_SAMPLE)) path = PATH_EXTSCAN;
        else if (instr_q == OP_IDCODE)                        path = PATH_IDENT;
        else                                                  path = PATH_BYPASS;
    end

    assign so = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h8006302F
) (
    input  logic     tck,
    input  logic     trst_n,
    input  logic     tdi,
    input  tap_ctl_t ctl,
    input  dr_path_e path,
    input  logic     ext_so,
    output logic     so,
    output logic     ext_sel,
    output logic     ext_capture,
    output logic     ext_shift,
    output logic     ext_update
);

    localparam int MSB = ID_W - 1;

    logic         byp_q;
    logic [MSB:0] id_q;
    logic         use_byp;
    logic         use_id;

    assign use_byp = (path == PATH_BYPASS);
    assign use_id  = (path == PATH_IDENT);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (use_byp) begin
            if (ctl.dr_load)       byp_q <= 1'b0;
            else if (ctl.dr_shift) byp_q <= tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_q <= ID_VALUE;
        end else if (use_id) begin
            if (ctl.dr_load)       id_q <= ID_VALUE;
            else if (ctl.dr_shift) id_q <= {tdi, id_q[MSB:1]};
        end
    end

    assign ext_sel     = (path == PATH_EXTSCAN);
    assign ext_capture = ext_sel && ctl.dr_load;
    assign ext_shift   = ext_sel && ctl.dr_shift;
    assign ext_update  = ext_sel && ctl.dr_update;

    always_comb begin
        unique case (path)
            PATH_IDENT:   so = id_q[0];
            PATH_EXTSCAN: so = ext_so;
            default:      so = byp_q;
        endcase
    end

endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int              IR_W     = 8,
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h8006302F
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_en,
    input  logic ext_so,
    output logic ext_sel,
    output logic ext_capture,
    output logic ext_shift,
    output logic ext_update
);

    tap_state_e state;
    tap_ctl_t   ctl;
    dr_path_e   path;
    logic       ir_so;
    logic       dr_so;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state),
        .ctl    (ctl)
    );

    tap_ir #(.IR_W(IR_W)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .ctl    (ctl),
        .so     (ir_so),
        .path   (path)
    );

    tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .tdi         (tdi),
        .ctl         (ctl),
        .path        (path),
        .ext_so      (ext_so),
        .so          (dr_so),
        .ext_sel     (ext_sel),
        .ext_capture (ext_capture),
        .ext_shift   (ext_shift),
        .ext_update  (ext_update)
    );

    // Output stage on the falling edge gives the far end a half period of hold.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= ctl.ir_shift || ctl.dr_shift;
            if (ctl.ir_shift)      tdo <= ir_so;
            else if (ctl.dr_shift) tdo <= dr_so;
            else                   tdo <= 1'b0;
        end
    end

endmodule

// File: rtl/tap_ctrl_chk.sv
`timescale 1ns/1ps
module tap_ctrl_chk
    import tap_pkg::*;
#(
    parameter int              IR_W     = 8,
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h8006302F
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo_en,
    input tap_state_e      state,
    input dr_path_e        path,
    input logic [IR_W-1:0] ir_sr,
    input logic [ID_W-1:0] id_sr
);

    logic [2:0] ones;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)        ones <= '0;
        else if (!tms)      ones <= '0;
        else if (ones < 3'd5) ones <= ones + 3'd1;
    end

    assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones == 3'd5) |-> (state == TS_RESET));

    assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == TS_IR_CAP) |-> (ir_sr[1:0] == 2'b01));

    assert_enable_shift_R5: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> ((state == TS_IR_SHIFT) || (state == TS_DR_SHIFT)));

    assert_path_change_R6: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(path) |-> (($past(state) == TS_IR_UPD) || ($past(state) == TS_RESET)));

    assert_id_recapture_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (($past(state) == TS_DR_EXIT2) && (state == TS_DR_SHIFT) && (path == PATH_IDENT))
        |-> (id_sr == ID_VALUE));

    assert_reset_bypass_R11: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(state) == TS_RESET) |-> (path == PATH_BYPASS));

endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .tdo_en (tdo_en),
    .state  (state),
    .path   (path),
    .ir_sr  (u_ir.sr_q),
    .id_sr  (u_dr.id_q)
);

// File: tb/tap_ctrl_tb.sv
`timescale 1ns/1ps
module tap_ctrl_tb;

    localparam logic [31:0] IDV = 32'h8006302F;
    // bench-side state numbering
    localparam int S_TLR = 0, S_RTI = 1;
    localparam int S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5, S_PDR = 6, S_E2D = 7, S_UDR = 8;
    localparam int S_SIR = 9, S_CIR = 10, S_HIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic ext_so = 1'b0;
    logic tdo, tdo_en, ext_sel, ext_capture, ext_shift, ext_update;

    int vectors = 0;
    int misses  = 0;

    // reference model
    int         ms;
    logic [7:0] m_ir, m_ins;
    logic       m_byp;
    logic [31:0] m_id;
    logic       m_tdo, m_en;

    always #2.5 tck = ~tck;

    tap_ctrl u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_en(tdo_en), .ext_so(ext_so),
        .ext_sel(ext_sel), .ext_capture(ext_capture),
        .ext_shift(ext_shift), .ext_update(ext_update)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nstate(int s, bit t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDR : S_RTI;
            S_SDR: return t ? S_SIR : S_CDR;
            S_SIR: return t ? S_TLR : S_CIR;
            S_CDR, S_HDR: return t ? S_E1D : S_HDR;
            S_CIR, S_HIR: return t ? S_E1I : S_HIR;
            S_E1D: return t ? S_UDR : S_PDR;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_PIR: return t ? S_E2I : S_PIR;
            S_E2D: return t ? S_UDR : S_HDR;
            S_E2I: return t ? S_UIR : S_HIR;
            default: return t ? S_SDR : S_RTI; // both update states
        endcase
    endfunction

    function automatic int mpath(logic [7:0] ins); // 0 bypass, 1 id, 2 external
        if (ins == 8'h00 || ins == 8'h01) return 2;
        if (ins == 8'h04) return 1;
        return 0;
    endfunction

    task automatic model_reset();
        ms = S_TLR; m_ir = 8'h01; m_ins = 8'hFF; m_byp = 1'b0; m_id = IDV;
        m_tdo = 1'b0; m_en = 1'b0;
    endtask

    task automatic model_edge(input bit t, input bit d);
        int p;
        p = mpath(m_ins);
        if (ms == S_TLR)      m_ins = 8'hFF;
        else if (ms == S_UIR) m_ins = m_ir;
        if (ms == S_CIR || (ms == S_E2I && !t)) m_ir = 8'h01;
        else if (ms == S_HIR)                   m_ir = {d, m_ir[7:1]};
        if (ms == S_CDR || (ms == S_E2D && !t)) begin
            if (p == 0) m_byp = 1'b0;
            if (p == 1) m_id  = IDV;
        end else if (ms == S_HDR) begin
            if (p == 0) m_byp = d;
            if (p == 1) m_id  = {d, m_id[31:1]};
        end
        ms = nstate(ms, t);
    endtask

    task automatic model_neg();
        int p;
        p = mpath(m_ins);
        m_en = (ms == S_HIR) || (ms == S_HDR);
        if (ms == S_HIR)      m_tdo = m_ir[0];
        else if (ms == S_HDR) m_tdo = (p == 2) ? ext_so : (p == 1) ? m_id[0] : m_byp;
        else                  m_tdo = 1'b0;
    endtask

    task automatic compare_all();
        bit sel;
        sel = (mpath(m_ins) == 2);
        check(tdo_en === m_en, "R3 R5 tdo_en", {31'd0, tdo_en}, {31'd0, m_en});
        check(tdo === m_tdo, "R4 R7 R8 R9 tdo", {31'd0, tdo}, {31'd0, m_tdo});
        check(ext_sel === sel, "R6 R10 ext_sel", {31'd0, ext_sel}, {31'd0, sel});
        check(ext_capture === (sel && (ms == S_CDR || (ms == S_E2D && !tms))), "R10 ext_capture",
              {31'd0, ext_capture}, {31'd0, sel && (ms == S_CDR || (ms == S_E2D && !tms))});
        check(ext_shift === (sel && ms == S_HDR), "R10 ext_shift",
              {31'd0, ext_shift}, {31'd0, sel && ms == S_HDR});
        check(ext_update === (sel && ms == S_UDR), "R10 ext_update",
              {31'd0, ext_update}, {31'd0, sel && ms == S_UDR});
    endtask

    task automatic tick(input bit t, input bit d);
        tms = t; tdi = d; ext_so = ~d;
        @(posedge tck);
        model_edge(t, d);
        @(negedge tck);
        #1;
        model_neg();
        compare_all();
    endtask

    task automatic scan_ir(input logic [7:0] din, output logic [7:0] dout);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 8; i++) begin
            dout[i] = tdo;
            tick(i == 7, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #1000000;
        misses++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        logic [7:0]  ir_out;
        logic [31:0] dr_out;
        model_reset();
        repeat (3) @(negedge tck);
        #1;
        check(tdo_en === 1'b0 && tdo === 1'b0, "R1 reset outputs", {30'd0, tdo_en, tdo}, 32'd0);
        check(ext_sel === 1'b0, "R1 reset instruction", {31'd0, ext_sel}, 32'd0);
        trst_n = 1'b1;
        tick(0, 0);

        // bypass straight out of reset
        scan_dr(8, 32'hA5, dr_out);
        check(dr_out[0] === 1'b0, "R11 reset not ident", dr_out, 32'd0);
        check(dr_out[7:0] === 8'h4A, "R8 bypass delay", dr_out, 32'h4A);

        // capture pattern and ident
        scan_ir(8'h04, ir_out);
        check(ir_out[1:0] === 2'b01, "R4 ir capture", {24'd0, ir_out}, 32'h01);
        scan_dr(32, 32'h0, dr_out);
        check(dr_out === IDV, "R7 ident value", dr_out, IDV);

        // DR pause recapture: four shifts, then back to shift
        tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 0); tick(0, 0); tick(0, 0); tick(1, 0);
        tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        check(tdo === 1'b1, "R9 dr recapture", {31'd0, tdo}, 32'd1);
        tick(1, 0); tick(1, 0); tick(0, 0);

        // IR pause recapture: two shifts, then back to shift
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(1, 1); tick(0, 0); tick(1, 0); tick(0, 0);
        check(tdo === 1'b1, "R9 ir recapture", {31'd0, tdo}, 32'd1);
        for (int i = 0; i < 8; i++) tick(i == 7, 1);
        tick(1, 0); tick(0, 0);
        scan_dr(8, 32'h3C, dr_out);
        check(dr_out[7:0] === 8'h78, "R6 all-ones bypass", dr_out, 32'h78);

        // private code
        scan_ir(8'h25, ir_out);
        scan_dr(8, 32'hC3, dr_out);
        check(dr_out[7:0] === 8'h86, "R6 private bypass", dr_out, 32'h86);

        // external stub opcodes
        scan_ir(8'h00, ir_out);
        check(ext_sel === 1'b1, "R10 extest select", {31'd0, ext_sel}, 32'd1);
        scan_dr(6, 32'h15, dr_out);
        scan_ir(8'h01, ir_out);
        check(ext_sel === 1'b1, "R10 sample select", {31'd0, ext_sel}, 32'd1);
        tick(1, 0);
        tick(0, 0);
        check(ext_capture === 1'b1, "R10 capture strobe", {31'd0, ext_capture}, 32'd1);
        tick(0, 1); tick(0, 0); tick(1, 1); tick(1, 0); tick(0, 0);

        // five ones from mid shift, ident must not survive
        scan_ir(8'h04, ir_out);
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check(ext_sel === 1'b0 && tdo_en === 1'b0, "R2 five ones", {30'd0, ext_sel, tdo_en}, 32'd0);
        tick(0, 0);
        scan_dr(8, 32'hFF, dr_out);
        check(dr_out[7:0] === 8'hFE, "R2 R11 after tlr bypass", dr_out, 32'hFE);

        // asynchronous reset during a shift
        scan_ir(8'h04, ir_out);
        tick(1, 0); tick(0, 0); tick(0, 0);
        check(tdo_en === 1'b1, "R5 enable in shift", {31'd0, tdo_en}, 32'd1);
        trst_n = 1'b0;
        #1;
        check(tdo_en === 1'b0 && tdo === 1'b0, "R1 async clear", {30'd0, tdo_en, tdo}, 32'd0);
        model_reset();
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        tick(0, 0);
        scan_dr(8, 32'h01, dr_out);
        check(dr_out[7:0] === 8'h02, "R1 R11 reset bypass", dr_out, 32'h02);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule